// File: doc/BRIEF.md
# Serial Open-Drain Port Expander Controller

This controller drives a bank of open-drain joystick-port outputs through an external serial-in shift register that has an output latch. It also reads the same port's pins back through an external 2-to-1 multiplexer. Four lines go out: serial data, shift clock, latch clock and an output enable. Five sense lines come back and carry ten pins. The multiplexer select is not a separate wire, because the latch clock level picks which half of the pins the sense lines carry.

The user side is simple. It presents an output word in which a 1 releases a pin and a 0 pulls it low. It receives a word of sampled pins and a one-cycle done pulse. The controller never stops: it loads the word, shifts it out, latches it, reads both halves, and starts again.

The external register clears to all zeros, which would pull every pin low. For this reason the output enable stays off after reset until a word of all ones has been shifted and latched.

Top module: `pexp_ctrl`

## Requirements
- R1: Each update shifts exactly N_OUT bits (default 12) on `exp_sclk_o`, then raises `exp_lclk_o` once to latch them. The shift clock stays low while the latch clock is high.
- R2: Bits leave most significant first. `exp_ser_o` changes only when the shift clock falls, so it is stable at every rising shift-clock edge.
- R3: After reset `exp_oe_o` is 0. The first update sends all ones whatever `out_word_i` holds. `exp_oe_o` rises when that latch-high phase ends, as the latch clock falls, and stays 1 until reset.
- R4: Outputs are not inverted. After each later update, bit i of the latched external word equals bit i of the `out_word_i` value taken for that update.
- R5: Sense line k is sampled while the latch clock is high and lands in `in_pins_o[k+N_LINES]`. It is sampled again while the latch clock is low and lands in `in_pins_o[k]`.
- R6: Each sample is taken only after the latch clock has held its level for SETTLE clocks (SETTLE at least 2), counted from the edge that changed it.
- R7: `out_word_i` is taken once, in the first cycle of each update. A change made later in that update does not alter the word being shifted and is sent in the following update.
- R8: `done_o` is high for exactly one cycle per update, in the cycle that `in_pins_o` takes both new halves.
- R9: Updates repeat without pause. Latch-clock rising edges are 2 + 2·N_OUT·HALF + 2·SETTLE clocks apart, and that span must be under 1000 ns at CLK_PERIOD_NS (checked at elaboration).
- R10: In reset, `exp_sclk_o`, `exp_lclk_o`, `exp_oe_o` and `done_o` are 0, and `in_pins_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low reset |
| out_word_i | input | N_OUT (12) | Desired pin levels, 1 = released |
| in_pins_o | output | 2·N_LINES (10) | Sampled pin levels |
| done_o | output | 1 | One-cycle pulse when both halves are captured |
| exp_ser_o | output | 1 | Serial data to the shift register |
| exp_sclk_o | output | 1 | Shift clock |
| exp_lclk_o | output | 1 | Latch clock, also the readback multiplexer select |
| exp_oe_o | output | 1 | Output enable for the latched bits (1 = enabled) |
| exp_rd_i | input | N_LINES (5) | Sense lines from the multiplexer |

## Verification
The bench builds the block with HALF = 2 and SETTLE = 3. HALF = 2 brings the counter variant of the shift-clock divider into play, which the default of 1 leaves out. SETTLE = 3 lets the bench model a multiplexer whose select reaches the sense lines two clocks late, so a sample taken one clock early would read the wrong half of the pins. With these values an update lasts 56 clocks at the 10 ns bench period. That makes the under-1000 ns rule and the exact span of an update directly measurable.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

   typedef enum logic [1:0] {
      SEQ_LOAD,
      SEQ_SHIFT,
      SEQ_HOLD_HI,
      SEQ_HOLD_LO
   } seq_state_e;

   // clocks from one latch-clock rise to the next
   function automatic int update_cycles(input int n_out, input int half, input int settle);
      return 2 + 2 * n_out * half + 2 * settle;
   endfunction

endpackage

// File: rtl/pexp_tick.sv
module pexp_tick #(
   parameter int HALF = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   output logic tick_o
);

   generate
      if (HALF == 1) begin : g_every
         logic unused_tick;
         assign unused_tick = ^{clk_i, rst_ni, restart_i};
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HALF + 1);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;

         assign tick_o = (cnt_q == LAST);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (restart_i || tick_o) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pexp_serializer.sv
module pexp_serializer #(
   parameter int N_BITS = 12,
   parameter int HALF   = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [N_BITS-1:0] word_i,
   output logic              ser_o,
   output logic              sclk_o,
   output logic              fin_o
);

   localparam int IW = $clog2(N_BITS + 1);
   localparam logic [IW-1:0] LAST_BIT = IW'(N_BITS - 1);

   logic [N_BITS-1:0] sreg_q;
   logic [IW-1:0]     idx_q;
   logic              busy_q;
   logic              sclk_q;
   logic              fin_q;
   logic              tick;

   pexp_tick #(.HALF(HALF)) i_tick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (load_i),
      .tick_o    (tick)
   );

   assign ser_o  = sreg_q[N_BITS-1];
   assign sclk_o = sclk_q;
   assign fin_o  = fin_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sreg_q <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (load_i) begin
            sreg_q <= word_i;
            idx_q  <= '0;
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
         end else if (busy_q && tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
            end else begin
               sclk_q <= 1'b0;
               sreg_q <= sreg_q << 1;
               if (idx_q == LAST_BIT) begin
                  busy_q <= 1'b0;
                  fin_q  <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end
   end

   AST_SER_STABLE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sclk_q) |-> $stable(ser_o)); // R2

   AST_FIN_WITH_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_q |-> !sclk_q && !busy_q); // R1

endmodule

// File: rtl/pexp_readback.sv
module pexp_readback #(
   parameter int N_LINES = 5,
   parameter int SETTLE  = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 window_i,
   input  logic                 sel_i,
   input  logic [N_LINES-1:0]   rd_i,
   output logic                 settled_o,
   output logic [2*N_LINES-1:0] pins_o,
   output logic                 done_o
);

   localparam int SW = $clog2(SETTLE + 1);
   localparam logic [SW-1:0] LAST_WAIT = SW'(SETTLE - 1);

   logic [SW-1:0]          wait_q;
   logic [N_LINES-1:0]     hi_q;
   logic [2*N_LINES-1:0]   pins_q;
   logic                   done_q;

   assign settled_o = window_i && (wait_q == LAST_WAIT);
   assign pins_o    = pins_q;
   assign done_o    = done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wait_q <= '0;
         hi_q   <= '0;
         pins_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!window_i || settled_o) begin
            wait_q <= '0;
         end else begin
            wait_q <= wait_q + 1'b1;
         end
         if (settled_o) begin
            if (sel_i) begin
               hi_q <= rd_i;
            end else begin
               pins_q <= {hi_q, rd_i};
               done_q <= 1'b1;
            end
         end
      end
   end

   AST_SAMPLE_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      settled_o |-> $stable(sel_i)); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q); // R8

   AST_PINS_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_q |-> $stable(pins_q)); // R8

endmodule

// File: rtl/pexp_ctrl.sv
module pexp_ctrl #(
   parameter int N_OUT         = 12,
   parameter int N_LINES       = 5,
   parameter int HALF          = 1,
   parameter int SETTLE        = 2,
   parameter int CLK_PERIOD_NS = 10
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [N_OUT-1:0]     out_word_i,
   output logic [2*N_LINES-1:0] in_pins_o,
   output logic                 done_o,
   output logic                 exp_ser_o,
   output logic                 exp_sclk_o,
   output logic                 exp_lclk_o,
   output logic                 exp_oe_o,
   input  logic [N_LINES-1:0]   exp_rd_i
);
   import pexp_pkg::*;

   localparam int UPDATE_CYCLES = update_cycles(N_OUT, HALF, SETTLE);
   localparam int UPDATE_NS     = UPDATE_CYCLES * CLK_PERIOD_NS;

   generate
      if (N_OUT < 1 || N_OUT > 32) begin : g_bad_width
         $error("N_OUT must be within 1..32");
      end
      if (N_LINES < 1) begin : g_bad_lines
         $error("N_LINES must be at least 1");
      end
      if (HALF < 1) begin : g_bad_half
         $error("HALF must be at least 1");
      end
      if (SETTLE < 2) begin : g_bad_settle
         $error("SETTLE must be at least 2");
      end
      if (UPDATE_NS >= 1000) begin : g_too_slow
         $error("one update must take less than 1000 ns");
      end
   endgenerate

   seq_state_e        state_q;
   logic              first_q;
   logic              oe_q;
   logic              lclk_q;
   logic              load;
   logic              window;
   logic              fin;
   logic              settled;
   logic [N_OUT-1:0]  word_sel;

   assign load     = (state_q == SEQ_LOAD);
   assign window   = (state_q == SEQ_HOLD_HI) || (state_q == SEQ_HOLD_LO);
   assign word_sel = first_q ? {N_OUT{1'b1}} : out_word_i;

   pexp_serializer #(.N_BITS(N_OUT), .HALF(HALF)) i_ser (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .word_i (word_sel),
      .ser_o  (exp_ser_o),
      .sclk_o (exp_sclk_o),
      .fin_o  (fin)
   );

   pexp_readback #(.N_LINES(N_LINES), .SETTLE(SETTLE)) i_rb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .window_i  (window),
      .sel_i     (lclk_q),
      .rd_i      (exp_rd_i),
      .settled_o (settled),
      .pins_o    (in_pins_o),
      .done_o    (done_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_LOAD;
         first_q <= 1'b1;
         oe_q    <= 1'b0;
         lclk_q  <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_LOAD: state_q <= SEQ_SHIFT;
            SEQ_SHIFT: begin
               if (fin) begin
                  state_q <= SEQ_HOLD_HI;
                  lclk_q  <= 1'b1;
               end
            end
            SEQ_HOLD_HI: begin
               if (settled) begin
                  state_q <= SEQ_HOLD_LO;
                  lclk_q  <= 1'b0;
                  first_q <= 1'b0;
                  oe_q    <= 1'b1;
               end
            end
            SEQ_HOLD_LO: begin
               if (settled) begin
                  state_q <= SEQ_LOAD;
               end
            end
            default: state_q <= SEQ_LOAD;
         endcase
      end
   end

   assign exp_lclk_o = lclk_q;
   assign exp_oe_o   = oe_q;

   AST_OE_AFTER_FIRST_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(oe_q) |-> $fell(lclk_q)); // R3

   AST_OE_STAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_q |=> oe_q); // R3

   AST_NO_SHIFT_WHILE_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lclk_q |-> !exp_sclk_o); // R1

   AST_DONE_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (state_q == SEQ_LOAD) && !lclk_q); // R8

endmodule

// File: tb/test_pexp_ctrl.sv
module test_pexp_ctrl;

   localparam int CLK_NS  = 10;
   localparam int N_OUT   = 12;
   localparam int N_LINES = 5;
   localparam int HALF    = 2;
   localparam int SETTLE  = 3;
   localparam int LAG     = SETTLE - 1;
   localparam int PERIOD  = 2 + 2 * N_OUT * HALF + 2 * SETTLE;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [N_OUT-1:0]     out_word = '0;
   logic [2*N_LINES-1:0] in_pins;
   logic                 done;
   logic                 ser, sclk, lclk, oe;
   logic [N_LINES-1:0]   rd;
   logic [N_LINES-1:0]   hi_val = '0;
   logic [N_LINES-1:0]   lo_val = '0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_NS / 2) clk = ~clk;

   pexp_ctrl #(
      .N_OUT(N_OUT), .N_LINES(N_LINES), .HALF(HALF), .SETTLE(SETTLE), .CLK_PERIOD_NS(CLK_NS)
   ) i_pexp_ctrl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .out_word_i (out_word),
      .in_pins_o  (in_pins),
      .done_o     (done),
      .exp_ser_o  (ser),
      .exp_sclk_o (sclk),
      .exp_lclk_o (lclk),
      .exp_oe_o   (oe),
      .exp_rd_i   (rd)
   );

   // external shift register with output latch
   logic [N_OUT-1:0] ext_sr = '0;
   logic [N_OUT-1:0] ext_lat = '0;
   int sclk_rises = 0;
   int shifts_seen = 0;
   int cyc = 0;
   int last_rise = 0;
   int interval = 0;
   bit first_latch_seen = 1'b0;
   logic oe_at_first = 1'b1;

   always @(posedge sclk) begin
      ext_sr <= {ext_sr[N_OUT-2:0], ser};
      sclk_rises = sclk_rises + 1;
   end

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge lclk) begin
      ext_lat <= ext_sr;
      interval = cyc - last_rise;
      last_rise = cyc;
      shifts_seen = sclk_rises;
      sclk_rises = 0;
      if (!first_latch_seen) begin
         oe_at_first = oe;
         first_latch_seen = 1'b1;
      end
   end

   // multiplexer whose select reaches the outputs LAG clocks late
   logic [LAG-1:0] sel_pipe = '0;
   always @(posedge clk) sel_pipe <= {sel_pipe[LAG-2:0], lclk};
   assign rd = sel_pipe[LAG-1] ? hi_val : lo_val;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(sclk == 1'b0, "R10 sclk in reset", 32'(sclk), 0);
      check(lclk == 1'b0, "R10 lclk in reset", 32'(lclk), 0);
      check(oe == 1'b0, "R10 oe in reset", 32'(oe), 0);
      check(done == 1'b0, "R10 done in reset", 32'(done), 0);
      check(in_pins == '0, "R10 pins in reset", 32'(in_pins), 0);
   endtask

   task automatic t_first_update();
      int guard = 0;
      rst_n = 1'b1;
      while (!oe && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      check(oe == 1'b1, "R3 oe eventually asserted", 32'(oe), 1);
      check(oe_at_first == 1'b0, "R3 oe off at first latch", 32'(oe_at_first), 0);
      check(ext_lat == {N_OUT{1'b1}}, "R3 first latched word all ones", 32'(ext_lat), 32'hFFF);
      wait_done();
      wait_done();
      check(ext_lat == 12'h000, "R3 R4 user word follows the ones", 32'(ext_lat), 0);
      check(oe == 1'b1, "R3 oe stays on", 32'(oe), 1);
   endtask

   task automatic t_word(input logic [N_OUT-1:0] w);
      out_word = w;
      wait_done();
      check(ext_lat == w, "R4 R2 latched word", 32'(ext_lat), 32'(w));
      check(shifts_seen == N_OUT, "R1 shift clocks per update", 32'(shifts_seen), N_OUT);
   endtask

   task automatic t_mid_update();
      out_word = 12'h3C6;
      repeat (5) @(negedge clk);
      out_word = 12'hC39;
      wait_done();
      check(ext_lat == 12'h3C6, "R7 mid-update change held back", 32'(ext_lat), 32'h3C6);
      wait_done();
      check(ext_lat == 12'hC39, "R7 change sent next update", 32'(ext_lat), 32'hC39);
   endtask

   task automatic t_readback(input logic [N_LINES-1:0] h, input logic [N_LINES-1:0] l);
      hi_val = h;
      lo_val = l;
      wait_done();
      check(in_pins == {h, l}, "R5 R6 pins halves", 32'(in_pins), 32'({h, l}));
      @(negedge clk);
      check(done == 1'b0, "R8 done single cycle", 32'(done), 0);
   endtask

   task automatic t_timing();
      wait_done();
      wait_done();
      check(interval == PERIOD, "R9 update period in clocks", 32'(interval), 32'(PERIOD));
      check(interval * CLK_NS < 1000, "R9 update under 1 us", 32'(interval * CLK_NS), 999);
   endtask

   initial begin
      t_reset();
      t_first_update();
      t_word(12'hA5C);
      t_word(12'h800);
      t_word(12'h001);
      t_word(12'hFFF);
      t_word(12'h000);
      t_mid_update();
      t_readback(5'b10110, 5'b01001);
      t_readback(5'b00001, 5'b10000);
      t_readback(5'b11111, 5'b00000);
      t_timing();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule